// File: doc/BRIEF.md
# Burst SRAM Cycle Controller

This block decodes the clocked control inputs of a pipelined burst SRAM that sits behind a cache. Each rising edge samples the following inputs:

- two active-low address strobes, one driven by the processor and one by the cache controller;
- an active-low burst advance;
- three chip selects;
- a global write, a lane-write enable and two per-lane write enables.

From these the block classifies the edge as one of: deselect, begin a burst read, begin a burst write, continue the burst, or suspend it.

For the edge being set up, the block drives these signals as combinational outputs of the current inputs:

- an address-register load;
- a burst-counter advance;
- per-lane array write strobes for an 18-bit word made of two 9-bit lanes;
- a per-bit write mask.

A register reports the cycle class one clock later. The same register also gates the data output driver, because read data appears one clock after its address edge. The driver enable is further gated by an asynchronous active-low output enable.

Typical use: an address path loads its register on `load_addr_o`, and a burst counter steps on `adv_addr_o`. The storage array writes the lanes flagged in `lane_wr_o` at the same edge. The pad drivers follow `dq_drive_o`.

Top module: `sbsram_ctrl`

## Requirements
- R1: The part counts as selected only when `sel0_ni`=0, `sel1_i`=1 and `sel2_ni`=0. An effective strobe in an unselected state gives a deselect cycle, code 1, with no load, no advance and no lane write. A deselect cycle ends any open burst.
- R2: `cpu_strobe_ni`=0 with the part selected begins a burst read, code 2. It asserts `load_addr_o`, and the write inputs are ignored (`lane_wr_o`=0).
- R3: When `sel0_ni`=1, a low `cpu_strobe_ni` is ignored. The edge is decided as if that strobe were high.
- R4: `ctl_strobe_ni`=0 without an effective processor strobe, with the part selected, begins a burst with `load_addr_o`=1. The cycle is a write, code 3, when the write decode is non-zero, and a read, code 2, otherwise.
- R5: With no effective strobe and a burst open, `advance_ni`=0 continues the burst: code 4 for a read or 5 for a write, with `adv_addr_o`=1. `advance_ni`=1 suspends it: code 6 for a read or 7 for a write, with no advance. A write in either case strobes the decoded lanes. `load_addr_o` and `adv_addr_o` are never both high.
- R6: Write decode works as follows. `all_wr_ni`=0 selects both lanes. Otherwise, with `lane_wr_en_ni`=0, lane i is selected when `lane_wr_ni[i]`=0. Any other combination is a read. Lane 0 covers data bits 8:0 and lane 1 covers bits 17:9.
- R7: `wr_bits_o[9*i +: 9]` is all ones exactly when `lane_wr_o[i]`=1.
- R8: With no burst open, after reset or after a deselect, an edge with no effective strobe is idle, code 0. It does not advance and does not write.
- R9: `cycle_o` shows the class of the previous edge. It reads 0 after reset.
- R10: `dq_drive_o` is 1 only in the clock after a read-class edge (code 2, 4 or 6) while `out_en_ni`=0. It follows `out_en_ni` without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_strobe_ni | input | 1 | Processor address strobe, active low |
| ctl_strobe_ni | input | 1 | Cache-controller address strobe, active low |
| advance_ni | input | 1 | Burst advance, active low |
| sel0_ni | input | 1 | Chip select, active low, also gates processor strobe |
| sel1_i | input | 1 | Chip select, active high |
| sel2_ni | input | 1 | Chip select, active low |
| all_wr_ni | input | 1 | Global write of all lanes, active low |
| lane_wr_en_ni | input | 1 | Per-lane write enable, active low |
| lane_wr_ni | input | 2 | Per-lane write selects, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| cycle_o | output | 3 | Class of the previous edge (codes 0 to 7) |
| load_addr_o | output | 1 | Load external address at this edge |
| adv_addr_o | output | 1 | Advance burst counter at this edge |
| lane_wr_o | output | 2 | Lane write strobes for this edge |
| wr_bits_o | output | 18 | Per-bit write mask for this edge |
| dq_drive_o | output | 1 | Data output driver enable |

## Verification
The bench goes after the priority corners. The first is a processor strobe asserted together with a high first select. A design that fails to block it would start a read or a deselect where the table calls for continue or suspend. The second is both strobes low at once. Here a write that leaks onto the processor strobe would corrupt the array. The third is a continue after a deselect, which a design without the open-burst flag would turn into spurious writes and counter steps. The bench also toggles the output enable between edges. A registered enable would then lag by a cycle, and drive during writes would collide with incoming data.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_DESEL    = 3'd1,
    CYC_RD_BEGIN = 3'd2,
    CYC_WR_BEGIN = 3'd3,
    CYC_RD_NEXT  = 3'd4,
    CYC_WR_NEXT  = 3'd5,
    CYC_RD_HOLD  = 3'd6,
    CYC_WR_HOLD  = 3'd7
  } cyc_e;

  function automatic logic cyc_writes(cyc_e c);
    return (c == CYC_WR_BEGIN) || (c == CYC_WR_NEXT) || (c == CYC_WR_HOLD);
  endfunction

  function automatic logic cyc_reads(cyc_e c);
    return (c == CYC_RD_BEGIN) || (c == CYC_RD_NEXT) || (c == CYC_RD_HOLD);
  endfunction
endpackage

// File: rtl/sbsram_sel_decode.sv
module sbsram_sel_decode (
  input  logic sel0_ni,
  input  logic sel1_i,
  input  logic sel2_ni,
  input  logic cpu_strobe_ni,
  input  logic ctl_strobe_ni,
  output logic selected_o,
  output logic cpu_go_o,
  output logic ctl_go_o
);
  assign selected_o = ~sel0_ni & sel1_i & ~sel2_ni;
  // processor strobe is masked by the first select
  assign cpu_go_o   = ~cpu_strobe_ni & ~sel0_ni;
  assign ctl_go_o   = ~ctl_strobe_ni & ~cpu_go_o;
endmodule

// File: rtl/sbsram_wr_decode.sv
module sbsram_wr_decode #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             all_wr_ni,
  input  logic             lane_wr_en_ni,
  input  logic [LANES-1:0] lane_wr_ni,
  output logic [LANES-1:0] lane_mask_o,
  output logic             is_write_o
);
  always_comb begin
    if (!all_wr_ni)          lane_mask_o = '1;
    else if (!lane_wr_en_ni) lane_mask_o = ~lane_wr_ni;
    else                     lane_mask_o = '0;
  end
  assign is_write_o = |lane_mask_o;
endmodule

// File: rtl/sbsram_lane_expand.sv
module sbsram_lane_expand #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic [LANES-1:0] lane_i,
  output logic [DW-1:0]    bits_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bits_o[g*LANE_W +: LANE_W] = {LANE_W{lane_i[g]}};
  end
endmodule

// File: rtl/sbsram_cycle_fsm.sv
module sbsram_cycle_fsm
  import sbsram_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic selected_i,
  input  logic cpu_go_i,
  input  logic ctl_go_i,
  input  logic advance_ni,
  input  logic is_write_i,
  output cyc_e next_o,
  output cyc_e cyc_q_o,
  output logic rd_q_o
);
  logic open_q;
  cyc_e next;

  always_comb begin
    if (cpu_go_i)                 next = selected_i ? CYC_RD_BEGIN : CYC_DESEL;
    else if (ctl_go_i)            next = !selected_i ? CYC_DESEL
                                       : (is_write_i ? CYC_WR_BEGIN : CYC_RD_BEGIN);
    else if (!open_q)             next = CYC_IDLE;
    else if (!advance_ni)         next = is_write_i ? CYC_WR_NEXT : CYC_RD_NEXT;
    else                          next = is_write_i ? CYC_WR_HOLD : CYC_RD_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      cyc_q_o <= CYC_IDLE;
      rd_q_o  <= 1'b0;
    end else begin
      cyc_q_o <= next;
      rd_q_o  <= cyc_reads(next);
      if (next == CYC_DESEL)                                  open_q <= 1'b0;
      else if (next == CYC_RD_BEGIN || next == CYC_WR_BEGIN) open_q <= 1'b1;
    end
  end

  assign next_o = next;
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_strobe_ni,
  input  logic             ctl_strobe_ni,
  input  logic             advance_ni,
  input  logic             sel0_ni,
  input  logic             sel1_i,
  input  logic             sel2_ni,
  input  logic             all_wr_ni,
  input  logic             lane_wr_en_ni,
  input  logic [LANES-1:0] lane_wr_ni,
  input  logic             out_en_ni,
  output logic [2:0]       cycle_o,
  output logic             load_addr_o,
  output logic             adv_addr_o,
  output logic [LANES-1:0] lane_wr_o,
  output logic [DW-1:0]    wr_bits_o,
  output logic             dq_drive_o
);
  logic selected, cpu_go, ctl_go, is_write, rd_q;
  logic [LANES-1:0] lane_mask;
  cyc_e next, cyc_q;

  sbsram_sel_decode u_sel (
    .sel0_ni(sel0_ni), .sel1_i(sel1_i), .sel2_ni(sel2_ni),
    .cpu_strobe_ni(cpu_strobe_ni), .ctl_strobe_ni(ctl_strobe_ni),
    .selected_o(selected), .cpu_go_o(cpu_go), .ctl_go_o(ctl_go)
  );

  sbsram_wr_decode #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .all_wr_ni(all_wr_ni), .lane_wr_en_ni(lane_wr_en_ni),
    .lane_wr_ni(lane_wr_ni), .lane_mask_o(lane_mask), .is_write_o(is_write)
  );

  sbsram_cycle_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .selected_i(selected),
    .cpu_go_i(cpu_go), .ctl_go_i(ctl_go), .advance_ni(advance_ni),
    .is_write_i(is_write), .next_o(next), .cyc_q_o(cyc_q), .rd_q_o(rd_q)
  );

  assign load_addr_o = (next == CYC_RD_BEGIN) || (next == CYC_WR_BEGIN);
  assign adv_addr_o  = (next == CYC_RD_NEXT)  || (next == CYC_WR_NEXT);
  assign lane_wr_o   = cyc_writes(next) ? lane_mask : '0;

  sbsram_lane_expand #(.LANES(LANES), .LANE_W(LANE_W)) u_exp (
    .lane_i(lane_wr_o), .bits_o(wr_bits_o)
  );

  assign cycle_o    = cyc_q;
  assign dq_drive_o = rd_q & ~out_en_ni;
endmodule

// File: rtl/sbsram_ctrl_chk.sv
module sbsram_ctrl_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_strobe_ni,
  input logic             ctl_strobe_ni,
  input logic             sel0_ni,
  input logic             sel1_i,
  input logic             sel2_ni,
  input logic             out_en_ni,
  input logic [2:0]       cycle_o,
  input logic             load_addr_o,
  input logic             adv_addr_o,
  input logic [LANES-1:0] lane_wr_o,
  input logic [DW-1:0]    wr_bits_o,
  input logic             dq_drive_o
);
  assert_desel_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_strobe_ni || (!cpu_strobe_ni && !sel0_ni)) && !(!sel0_ni && sel1_i && !sel2_ni)
      |=> cycle_o == 3'd1);

  assert_cpu_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_strobe_ni && !sel0_ni && sel1_i && !sel2_ni) |-> load_addr_o && lane_wr_o == '0);

  assert_load_adv_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_addr_o && adv_addr_o));

  assert_bits_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wr_bits_o) == LANE_W * $countones(lane_wr_o));

  assert_write_class_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_wr_o != '0) |=> (cycle_o == 3'd3 || cycle_o == 3'd5 || cycle_o == 3'd7));

  assert_drive_oe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_drive_o |-> !out_en_ni);
endmodule

bind sbsram_ctrl sbsram_ctrl_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_sbsram_ctrl.sv
module sim_sbsram_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_n = 1, ctl_n = 1, adv_n = 1, s0n = 1, s1 = 0, s2n = 1;
  logic all_n = 1, be_n = 1, oe_n = 1;
  logic [1:0] we_n = 2'b11;
  logic [2:0] cyc;
  logic load, adv;
  logic [1:0] lane;
  logic [17:0] bits;
  logic drive;

  int n_chk = 0, n_bad = 0;
  bit m_open = 0, m_rd = 0;
  int m_cyc = 0;

  always #4 clk = ~clk;

  sbsram_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_strobe_ni(cpu_n), .ctl_strobe_ni(ctl_n),
    .advance_ni(adv_n), .sel0_ni(s0n), .sel1_i(s1), .sel2_ni(s2n),
    .all_wr_ni(all_n), .lane_wr_en_ni(be_n), .lane_wr_ni(we_n), .out_en_ni(oe_n),
    .cycle_o(cyc), .load_addr_o(load), .adv_addr_o(adv), .lane_wr_o(lane),
    .wr_bits_o(bits), .dq_drive_o(drive)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_mask();
    if (!all_n) return 3;
    if (!be_n)  return int'(~we_n) & 3;
    return 0;
  endfunction

  function automatic int exp_next();
    bit sel = !s0n && s1 && !s2n;
    bit wr  = exp_mask() != 0;
    if (!cpu_n && !s0n) return sel ? 2 : 1;
    if (!ctl_n)         return sel ? (wr ? 3 : 2) : 1;
    if (!m_open)        return 0;
    if (!adv_n)         return wr ? 5 : 4;
    return wr ? 7 : 6;
  endfunction

  function automatic string tag_of(int c);
    case (c)
      0: return "R8";
      1: return "R1";
      2: return "R2";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int expand(int m);
    return ((m & 1) ? 18'h001FF : 0) | ((m & 2) ? 18'h3FE00 : 0);
  endfunction

  // one edge: drive after falling edge, check comb outputs, then registered ones
  task automatic step(string tag, bit c, bit k, bit a, bit x0, bit x1, bit x2,
                      bit g, bit b, bit [1:0] w, bit o);
    int nx, wm;
    @(negedge clk);
    cpu_n = c; ctl_n = k; adv_n = a; s0n = x0; s1 = x1; s2n = x2;
    all_n = g; be_n = b; we_n = w; oe_n = o;
    #1;
    nx = exp_next();
    wm = (nx == 3 || nx == 5 || nx == 7) ? exp_mask() : 0;
    chk({tag, " load R2 R4"}, int'(load), int'(nx == 2 || nx == 3));
    chk({tag, " adv R5"}, int'(adv), int'(nx == 4 || nx == 5));
    chk({tag, " lanes R6"}, int'(lane), wm);
    chk({tag, " bits R7"}, int'(bits), expand(wm));
    chk({tag, " drive R10"}, int'(drive), int'(m_rd && !o));
    @(posedge clk);
    m_cyc = nx;
    m_rd  = (nx == 2 || nx == 4 || nx == 6);
    if (nx == 1) m_open = 0;
    else if (nx == 2 || nx == 3) m_open = 1;
    #1;
    chk({tag, " cycle R9 ", tag_of(nx)}, int'(cyc), m_cyc);
    chk({tag, " drive R10"}, int'(drive), int'(m_rd && !oe_n));
  endtask

  initial begin : watchdog
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #3;
    chk("reset cycle R9", int'(cyc), 0);
    chk("reset drive R10", int'(drive), 0);
    chk("reset lanes R8", int'(lane), 0);
    #10 rst_n = 1;
    // idle before any burst
    step("idle R8", 1, 1, 0, 0, 1, 0, 0, 1, 2'b00, 0);
    // processor read ignores a global write
    step("cpu R2", 0, 1, 1, 0, 1, 0, 0, 0, 2'b00, 0);
    // both strobes low: processor wins, read
    step("both R2", 0, 0, 1, 0, 1, 0, 0, 0, 2'b00, 0);
    // continue read, oe high
    step("next R5", 1, 1, 0, 0, 1, 0, 1, 1, 2'b11, 1);
    // blocked processor strobe, controller high: suspend read
    step("blocked R3", 0, 1, 1, 1, 1, 0, 1, 1, 2'b11, 0);
    // blocked processor strobe, controller low while unselected: deselect
    step("blocked desel R3", 0, 0, 1, 1, 1, 0, 1, 1, 2'b11, 0);
    // after deselect a continue is idle, no write
    step("after desel R8", 1, 1, 0, 0, 1, 0, 0, 1, 2'b11, 0);
    // controller write lane 0, lane 1, both, none
    step("ctl wr lane0 R4", 1, 0, 1, 0, 1, 0, 1, 0, 2'b10, 0);
    step("cont lane1 R6", 1, 1, 0, 0, 1, 0, 1, 0, 2'b01, 0);
    step("hold all R6", 1, 1, 1, 1, 0, 1, 0, 1, 2'b11, 0);
    step("ctl read R4", 1, 0, 1, 0, 1, 0, 1, 0, 2'b11, 0);
    // deselect via second and third selects
    step("desel s1 R1", 0, 1, 1, 0, 0, 0, 0, 1, 2'b00, 0);
    step("desel s2 R1", 1, 0, 1, 0, 1, 1, 0, 1, 2'b00, 0);
    // asynchronous oe after a read edge
    step("cpu R2", 0, 1, 1, 0, 1, 0, 1, 1, 2'b11, 0);
    @(negedge clk); #1;
    oe_n = 1; #1; chk("oe async R10", int'(drive), 0);
    oe_n = 0; #1; chk("oe async R10", int'(drive), int'(m_rd));
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit c, k, a, x0, x1, x2, g, b, o;
      bit [1:0] w;
      c  = ($urandom % 5) == 0;
      k  = ($urandom % 5) == 0;
      c = !c; k = !k;
      a  = $urandom % 2;
      if (($urandom % 10) < 7) begin x0 = 0; x1 = 1; x2 = 0; end
      else begin x0 = $urandom % 2; x1 = $urandom % 2; x2 = $urandom % 2; end
      g  = ($urandom % 4) != 0;
      b  = $urandom % 2;
      w  = 2'($urandom);
      o  = ($urandom % 4) == 0;
      step("rand", c, k, a, x0, x1, x2, g, b, w, o);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule